// File: doc/BRIEF.md
# Interrupt Status, Mask and Enable Unit

This block gathers single-cycle event pulses from the rest of a network controller into a sticky 32-bit status word. It drives one level-sensitive interrupt line towards the host. Software reaches three registers through a plain strobe-based read/write port: the status word, a mask word and a one-bit global enable. A read of the status word returns its contents and empties it in the same access. A handler therefore keeps reading until it sees zero.

The low half of the status word holds the receive, transmit, statistics, software, power and PHY events. The high half holds the bus-error, FIFO-overrun and reset-complete events. Status bit 15 is not stored. It reads as the OR of stored bits 25 down to 16, so one mask bit can enable every high-order error event.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the status word, mask and enable are zero, and both `irq_o` and `rdata_o` are low.
- R2: A pulse on `evt_i[n]` sets status bit n for every stored bit, which are bits 0-14, bit 16 and bits 20-25. The bit stays set until the status word is read.
- R3: A read at offset 0x10 returns the status word on `rdata_o` one cycle after the strobe and clears every stored bit, so a following read returns zero.
- R4: An event that arrives in the same cycle as a clearing read is not part of that read's data. It is kept and appears on the next read.
- R5: Status bit 15 reads as the OR of status bits 25 to 16. A pulse on `evt_i[15]` alone leaves the status word zero.
- R6: Status bits 17-19 and 26-31 always read zero, whatever events arrive.
- R7: The mask is a full 32-bit register at offset 0x14. The global enable is bit 0 of offset 0x18, and bits 31-1 of that offset read zero. Reads of either return the stored value one cycle after the strobe.
- R8: A write to offset 0x10 does not change the status word.
- R9: `irq_o` is registered. It is high one cycle after the global enable is set and the status word ANDed with the mask is non-zero, and low one cycle after either condition stops holding.
- R10: A read at any other offset returns zero. A write there changes neither the mask nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, bit n sets status bit n |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe and held until the next read |
| irq_o | output | 1 | Level interrupt request |

## Verification
If a status flop is wrong, the next status read shows the error directly on `rdata_o`. The interrupt line shows it one cycle after the bad state, as a request that is missing or that never drops. If the summary bit has gone stale, the only sign at the ports may be an interrupt that follows a high-order event with only bit 15 unmasked. The bench therefore covers that combination, and it covers the same-cycle race between an event and a clearing read, where a lost event would stay invisible until the following read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W = 32;

  // register offsets
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_MASK   = 8'h14;
  localparam logic [7:0] OFS_ENABLE = 8'h18;

  // stored status bits: 0-14, 16, 20-25
  localparam logic [REG_W-1:0] IMPL_MASK = 32'h03F1_7FFF;

  // summary bit and the range it covers
  localparam int unsigned SUM_BIT = 15;
  localparam int unsigned HI_LO   = 16;
  localparam int unsigned HI_HI   = 25;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_ENABLE
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] IMPL   = '1,
  parameter int unsigned SUM_BIT = 15,
  parameter int unsigned HI_LO   = 16,
  parameter int unsigned HI_HI   = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] view_o
);
  localparam logic [W-1:0] SUM_ONEHOT = W'(1) << SUM_BIT;
  localparam logic [W-1:0] STORED     = IMPL & ~SUM_ONEHOT;
  localparam logic [W-1:0] READABLE   = STORED | SUM_ONEHOT;

  logic [W-1:0] raw;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STORED[i]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    bit_q <= 1'b0;
        else if (clr_i) bit_q <= set_i[i];   // same-cycle event survives the clear
        else            bit_q <= bit_q | set_i[i];
      end
      assign raw[i] = bit_q;
    end else begin : g_tie
      assign raw[i] = 1'b0;
    end
  end

  always_comb begin
    view_o          = raw;
    view_o[SUM_BIT] = |raw[HI_HI:HI_LO];
  end

  // R2: stored bits stay set until cleared
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((view_o & $past(view_o) & STORED) == ($past(view_o) & STORED)));

  // R2: a pulse becomes visible on the following cycle
  p_set_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & STORED) |=> ((view_o & $past(set_i & STORED)) == $past(set_i & STORED)));

  // R6: unimplemented positions never read as one
  p_unimpl_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (view_o & ~READABLE) == '0);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_mask_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic         en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      en_o   <= 1'b0;
    end else begin
      if (wr_mask_i) mask_o <= wdata_i;
      if (wr_en_i)   en_o   <= wdata_i[0];
    end
  end

  // R7 / R10: configuration changes only through its own write strobe
  p_mask_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_o));
  p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_o));
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] view_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= en_i & (|(view_i & mask_i));
  end

  // R9: gated by the global enable and by the mask
  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);
  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_o);
  p_irq_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (view_i & mask_i) != '0) |=> irq_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic [REG_W-1:0] status_view;
  logic [REG_W-1:0] mask_q;
  logic             en_q;
  logic             rd_stat;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_STATUS): sel = SEL_STATUS;
      ADDR_W'(OFS_MASK):   sel = SEL_MASK;
      ADDR_W'(OFS_ENABLE): sel = SEL_ENABLE;
      default:             sel = SEL_NONE;
    endcase
  end

  assign rd_stat = req_i && !we_i && (sel == SEL_STATUS);

  irq_status_bank #(
    .W(REG_W), .IMPL(IMPL_MASK), .SUM_BIT(SUM_BIT), .HI_LO(HI_LO), .HI_HI(HI_HI)
  ) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (rd_stat),
    .view_o (status_view)
  );

  irq_cfg_regs #(.W(REG_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mask_i (req_i && we_i && (sel == SEL_MASK)),
    .wr_en_i   (req_i && we_i && (sel == SEL_ENABLE)),
    .wdata_i   (wdata_i),
    .mask_o    (mask_q),
    .en_o      (en_q)
  );

  irq_line #(.W(REG_W)) i_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .view_i (status_view),
    .mask_i (mask_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = status_view;
      SEL_MASK:   rd_mux = mask_q;
      SEL_ENABLE: rd_mux = {{(REG_W-1){1'b0}}, en_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_mux;
  end

  // R5: returned status always carries a consistent summary bit
  p_summary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> (rdata_o[SUM_BIT] == (|rdata_o[HI_HI:HI_LO])));

  // R3: a read with no concurrent event leaves the status empty
  p_rd_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && evt_i == '0) |=> (status_view == '0));

  // R8: writes to the status offset do not alter it
  p_wr_status_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && sel == SEL_STATUS && evt_i == '0) |=> $stable(status_view));

  // R7: upper enable bits read zero
  p_en_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel == SEL_ENABLE) |=> (rdata_o[REG_W-1:1] == '0));

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel == SEL_NONE) |=> (rdata_o == '0));
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;  // 50 MHz

  irq_status_unit i_irq_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam int NV = 8;
  localparam logic [31:0] V_EVT  [NV] = '{32'h0000_0001, 32'h0000_0040, 32'h0001_0000, 32'h0080_0000,
                                          32'h000E_0000, 32'h0000_8000, 32'hFC00_0000, 32'h03F1_7FFF};
  localparam logic [31:0] V_MASK [NV] = '{32'h0000_0001, 32'h0000_0001, 32'h0000_8000, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_4000};
  localparam logic        V_EN   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_RD   [NV] = '{32'h0000_0001, 32'h0000_0040, 32'h0001_8000, 32'h0080_8000,
                                          32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h03F1_FFFF};
  localparam logic        V_IRQ  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    reg_rd(8'h10, rd); check("R1 status", rd, 32'h0);
    reg_rd(8'h14, rd); check("R1 mask", rd, 32'h0);
    reg_rd(8'h18, rd); check("R1 enable", rd, 32'h0);

    // vector walk: R2 R3 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      reg_wr(8'h14, V_MASK[k]);
      reg_wr(8'h18, {31'b0, V_EN[k]});
      pulse(V_EVT[k]);
      @(negedge clk);
      check("R9 irq after event", {31'b0, irq}, {31'b0, V_IRQ[k]});
      reg_rd(8'h10, rd);
      check("R2/R5/R6 status read", rd, V_RD[k]);
      reg_rd(8'h10, rd);
      check("R3 status cleared", rd, 32'h0);
      check("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    end

    // R7: mask and enable read-back
    reg_wr(8'h14, 32'hA5C3_0F96);
    reg_rd(8'h14, rd); check("R7 mask", rd, 32'hA5C3_0F96);
    reg_wr(8'h18, 32'hFFFF_FFFF);
    reg_rd(8'h18, rd); check("R7 enable bit only", rd, 32'h0000_0001);

    // R4: event in the clearing read cycle
    pulse(32'h0000_0002);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h10; evt = 32'h0000_0400;
    @(negedge clk);
    req = 1'b0; evt = '0;
    check("R4 read excludes same-cycle event", rdata, 32'h0000_0002);
    reg_rd(8'h10, rd); check("R4 event kept", rd, 32'h0000_0400);

    // R8: status write ignored
    pulse(32'h0000_1000);
    reg_wr(8'h10, 32'hFFFF_FFFF);
    reg_rd(8'h10, rd); check("R8 write ignored", rd, 32'h0000_1000);
    reg_wr(8'h10, 32'hFFFF_FFFF);
    reg_rd(8'h10, rd); check("R8 no set from write", rd, 32'h0);

    // R10: unmapped offsets
    reg_wr(8'h1C, 32'h0);
    reg_wr(8'h04, 32'h0);
    reg_rd(8'h1C, rd); check("R10 unmapped read", rd, 32'h0);
    reg_rd(8'h14, rd); check("R10 mask untouched", rd, 32'hA5C3_0F96);
    reg_rd(8'h18, rd); check("R10 enable untouched", rd, 32'h1);

    // R9: enable toggling with a pending masked-in bit
    reg_wr(8'h14, 32'h0000_0008);
    reg_wr(8'h18, 32'h0);
    pulse(32'h0000_0008);
    @(negedge clk);
    check("R9 disabled", {31'b0, irq}, 32'h0);
    reg_wr(8'h18, 32'h1);
    @(negedge clk);
    check("R9 enabled pending", {31'b0, irq}, 32'h1);
    reg_wr(8'h14, 32'h0);
    @(negedge clk);
    check("R9 masked off", {31'b0, irq}, 32'h0);
    reg_rd(8'h10, rd); check("R2 bit held while masked", rd, 32'h0000_0008);

    // R1: asynchronous reset mid-run
    reg_wr(8'h14, 32'hFFFF_FFFF);
    pulse(32'h0000_0001);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 irq on reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    reg_rd(8'h10, rd); check("R1 status after reset", rd, 32'h0);
    reg_rd(8'h14, rd); check("R1 mask after reset", rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule